// File: doc/BRIEF.md
# Dual-Port Memory Access Arbiter

This block decides, clock by clock, which of two ports owns one memory array. The first port is a host bus that carries CPU and DMA cycles. The second port is a display-refresh controller cabled straight to the board. The second port claims the array by pulling one of several active-low select lines low. It then waits for an acknowledge, which says the array has been switched over to it.

Static configuration inputs set three things: the board's block number, whether the board filters on the second-port page line, and which host cycles ask the refresh controller to yield. The arbiter asks the controller to yield by raising an override request. The controller answers on an active-low override-acknowledge line. A host cycle that cannot get the array is stalled by pulling the host ready line low.

The arbiter also gates the second port's read-data enable and its write strobe. A stray strobe therefore never reaches the array unless the block holds the array for that port.

Top module: `dpm_arbiter`

## Requirements
- R1: Second-port selects are active low, one line per block, and bit i of `sp_sel_n` belongs to block i. The board acknowledges only when the line indexed by `cfg_block` is low. Block code 3 never matches. At most one bit of `sp_ack` is ever high, and it is bit `cfg_block`.
- R2: With `cfg_page_en` low, a matching select is accepted whatever the value of `sp_page`. With `cfg_page_en` high, it is accepted only when `sp_page` equals `cfg_page_sel`, where low means page 0.
- R3: The board enters a second-port cycle only on a clock edge where a matching select is present and `ovr_ack_n` is high. `sp_ack` goes high in the cycle after that edge.
- R4: `ovr_req` is registered, one cycle behind `host_req`. The pair {`cfg_ovr_en`,`cfg_dma_only`} sets which host cycles raise it:
  - 00 raises it for every host access.
  - 01 never raises it.
  - 10 raises it for every host access.
  - 11 raises it only when `host_dma` is high.
- R5: When the override applies to the current host cycle, the host gets the array only after `ovr_ack_n` goes low. Until then `host_rdy` is low.
- R6: When `cfg_ovr_en` and `cfg_dma_kill` are both high, a host DMA cycle takes the array without waiting for `ovr_ack_n`, and no acknowledge is issued while it lasts. When `cfg_ovr_en` is low, `cfg_dma_kill` has no effect.
- R7: `sp_we` goes high only while the board holds the array for the second port and `sp_wr_n[cfg_block]` is low. A strobe that arrives before the acknowledge leaves `sp_we` low.
- R8: `sp_rd_oe` is high only while the acknowledge is high and `sp_rd_n[cfg_block]` is low.
- R9: Once acknowledged, the second port keeps the array for at least MIN_CYCLES clocks, even if its select goes away sooner.
- R10: If host and second port ask in the same clock, the second port wins unless an override applies to the host cycle and has been granted. A grant is held until its cycle ends: the host keeps the array while `host_req` stays high.
- R11: After reset no port owns the array, `sp_ack` is all zero, `ovr_req` is low, and `host_rdy` is high while `host_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_block | input | 2 | Block number this board answers on the second port |
| cfg_page_en | input | 1 | Enable page filtering |
| cfg_page_sel | input | 1 | Page this board answers when filtering |
| cfg_ovr_en | input | 1 | Override policy bit, high half of the mode pair |
| cfg_dma_only | input | 1 | Override policy bit, low half of the mode pair |
| cfg_dma_kill | input | 1 | Shut off the second port during host DMA |
| host_req | input | 1 | Host access to this board |
| host_dma | input | 1 | Current host access is a DMA cycle |
| host_rdy | output | 1 | Host ready; low stalls the host |
| host_grant | output | 1 | Array is connected to the host |
| sp_sel_n | input | 3 | Second-port block selects, active low |
| sp_page | input | 1 | Second-port page line |
| sp_rd_n | input | 3 | Second-port read enables, active low |
| sp_wr_n | input | 3 | Second-port write strobes, active low |
| ovr_ack_n | input | 1 | Override granted by the controller, active low |
| sp_ack | output | 3 | Second-port acknowledge, one bit per block |
| ovr_req | output | 1 | Override request to the controller |
| sp_rd_oe | output | 1 | Drive second-port read data |
| sp_we | output | 1 | Second-port write into the array |

## Verification
The bench builds the block with three blocks, a 2-bit block code and MIN_CYCLES set to 3. The short minimum window lets the bench count the whole acknowledge hold edge by edge: a select that lasts one cycle must still be acknowledged for exactly three cycles. Because the configuration comes in on ports, a single build reaches all four override modes, both page-filter settings, the unused block code and the DMA shut-off. A contest between host and second port runs from first request to host grant in five edges.

// File: rtl/dpm_arb_pkg.sv
package dpm_arb_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE = 2'd0,
      ARB_SP   = 2'd1,
      ARB_HOST = 2'd2
   } arb_state_t;

   // Override mode decode: {ovr_en, dma_only}
   function automatic logic ovr_applies(input logic ovr_en, input logic dma_only,
                                        input logic is_dma);
      case ({ovr_en, dma_only})
         2'b00:   return 1'b1;
         2'b01:   return 1'b0;
         2'b10:   return 1'b1;
         default: return is_dma;
      endcase
   endfunction
endpackage

// File: rtl/dpm_sp_match.sv
module dpm_sp_match #(
   parameter int NUM_BLK = 3,
   parameter int BLK_W   = 2
) (
   input  logic [BLK_W-1:0]   cfg_block,
   input  logic               cfg_page_en,
   input  logic               cfg_page_sel,
   input  logic [NUM_BLK-1:0] sp_sel_n,
   input  logic               sp_page,
   output logic [NUM_BLK-1:0] blk_hit,
   output logic               sp_hit
);
   logic page_ok;

   // one comparator per block line; codes >= NUM_BLK match nothing
   for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
      assign blk_hit[i] = (cfg_block == BLK_W'(i)) && !sp_sel_n[i];
   end

   assign page_ok = !cfg_page_en || (sp_page == cfg_page_sel);
   assign sp_hit  = page_ok && (|blk_hit);
endmodule

// File: rtl/dpm_ovr_policy.sv
module dpm_ovr_policy
   import dpm_arb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_ovr_en,
   input  logic cfg_dma_only,
   input  logic cfg_dma_kill,
   input  logic host_req,
   input  logic host_dma,
   output logic ovr_cond,
   output logic dma_kill,
   output logic ovr_req
);
   assign ovr_cond = host_req && ovr_applies(cfg_ovr_en, cfg_dma_only, host_dma);
   assign dma_kill = host_req && host_dma && cfg_ovr_en && cfg_dma_kill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovr_req <= 1'b0;
      else        ovr_req <= ovr_cond;
   end

   // R4: request follows a host access of an override-eligible type
   p_ovr_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && cfg_ovr_en && !cfg_dma_only) |=> ovr_req)
      else $error("p_ovr_follow_r4");
endmodule

// File: rtl/dpm_arb_fsm.sv
module dpm_arb_fsm
   import dpm_arb_pkg::*;
#(
   parameter int MIN_CYCLES = 4,
   localparam int CNT_W     = $clog2(MIN_CYCLES + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_req,
   input  logic       ovr_cond,
   input  logic       dma_kill,
   input  logic       ovr_ack_n,
   input  logic       sp_hit,
   output arb_state_t state
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYCLES - 1);

   logic [CNT_W-1:0] cnt;
   logic             host_ok, sp_go;

   // host may take the array: forced DMA, granted override, or uncontested
   assign host_ok = host_req && (dma_kill || (ovr_cond ? !ovr_ack_n : !sp_hit));
   assign sp_go   = sp_hit && ovr_ack_n && !host_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ARB_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            ARB_IDLE: begin
               cnt <= '0;
               if (host_ok)    state <= ARB_HOST;
               else if (sp_go) state <= ARB_SP;
            end
            ARB_SP: begin
               if (cnt == LAST) begin
                  if (!sp_hit) state <= ARB_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ARB_HOST: if (!host_req) state <= ARB_IDLE;
            default:  state <= ARB_IDLE;
         endcase
      end
   end

   // R9: second port keeps the array through its minimum window
   p_min_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ARB_SP && cnt != LAST) |=> state == ARB_SP)
      else $error("p_min_hold_r9");

   // R10: host grant is not revoked mid-cycle
   p_host_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ARB_HOST && host_req) |=> state == ARB_HOST)
      else $error("p_host_hold_r10");
endmodule

// File: rtl/dpm_arbiter.sv
module dpm_arbiter
   import dpm_arb_pkg::*;
#(
   parameter int NUM_BLK    = 3,
   parameter int BLK_W      = 2,
   parameter int MIN_CYCLES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BLK_W-1:0]   cfg_block,
   input  logic               cfg_page_en,
   input  logic               cfg_page_sel,
   input  logic               cfg_ovr_en,
   input  logic               cfg_dma_only,
   input  logic               cfg_dma_kill,
   input  logic               host_req,
   input  logic               host_dma,
   output logic               host_rdy,
   output logic               host_grant,
   input  logic [NUM_BLK-1:0] sp_sel_n,
   input  logic               sp_page,
   input  logic [NUM_BLK-1:0] sp_rd_n,
   input  logic [NUM_BLK-1:0] sp_wr_n,
   input  logic               ovr_ack_n,
   output logic [NUM_BLK-1:0] sp_ack,
   output logic               ovr_req,
   output logic               sp_rd_oe,
   output logic               sp_we
);
   if (NUM_BLK < 1 || NUM_BLK > (1 << BLK_W)) begin : g_bad_blk
      $error("NUM_BLK must fit the block code width");
   end
   if (MIN_CYCLES < 1) begin : g_bad_min
      $error("MIN_CYCLES must be at least 1");
   end

   logic [NUM_BLK-1:0] blk_hit;
   logic               sp_hit, ovr_cond, dma_kill;
   arb_state_t         state;
   logic [NUM_BLK-1:0] rd_sel, wr_sel;

   dpm_sp_match #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_match (
      .cfg_block(cfg_block), .cfg_page_en(cfg_page_en), .cfg_page_sel(cfg_page_sel),
      .sp_sel_n(sp_sel_n), .sp_page(sp_page), .blk_hit(blk_hit), .sp_hit(sp_hit));

   dpm_ovr_policy u_policy (
      .clk(clk), .rst_n(rst_n), .cfg_ovr_en(cfg_ovr_en), .cfg_dma_only(cfg_dma_only),
      .cfg_dma_kill(cfg_dma_kill), .host_req(host_req), .host_dma(host_dma),
      .ovr_cond(ovr_cond), .dma_kill(dma_kill), .ovr_req(ovr_req));

   dpm_arb_fsm #(.MIN_CYCLES(MIN_CYCLES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .ovr_cond(ovr_cond),
      .dma_kill(dma_kill), .ovr_ack_n(ovr_ack_n), .sp_hit(sp_hit), .state(state));

   for (genvar i = 0; i < NUM_BLK; i++) begin : g_port
      assign sp_ack[i] = (state == ARB_SP) && (cfg_block == BLK_W'(i));
      assign rd_sel[i] = sp_ack[i] && !sp_rd_n[i];
      assign wr_sel[i] = sp_ack[i] && !sp_wr_n[i];
   end

   assign sp_rd_oe   = |rd_sel;
   assign sp_we      = |wr_sel;
   assign host_grant = (state == ARB_HOST);
   assign host_rdy   = !host_req || host_grant;

   // R1: never more than one acknowledge
   p_ack_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sp_ack))
      else $error("p_ack_onehot_r1");

   // R3: acknowledge starts only from a matching select with no override granted
   p_ack_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|sp_ack) |-> $past(sp_hit && ovr_ack_n))
      else $error("p_ack_entry_r3");

   // R5: overridden host cycle gets the array only after the grant
   p_host_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(host_grant) && $past(ovr_cond && !dma_kill)) |-> $past(!ovr_ack_n))
      else $error("p_host_wait_r5");

   // R7: array write only inside an acknowledged second-port cycle
   p_we_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we |-> (|sp_ack) && !host_grant)
      else $error("p_we_gated_r7");
endmodule

// File: tb/dpm_arbiter_tb.sv
`timescale 1ns/100ps
module dpm_arbiter_tb_top;
   localparam int NB = 3;
   localparam int MC = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] cfg_block = 2'd1;
   logic cfg_page_en = 0, cfg_page_sel = 0, cfg_ovr_en = 0, cfg_dma_only = 0, cfg_dma_kill = 0;
   logic host_req = 0, host_dma = 0, host_rdy, host_grant;
   logic [NB-1:0] sp_sel_n = '1, sp_rd_n = '1, sp_wr_n = '1, sp_ack;
   logic sp_page = 0, ovr_ack_n = 1, ovr_req, sp_rd_oe, sp_we;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dpm_arbiter #(.NUM_BLK(NB), .BLK_W(2), .MIN_CYCLES(MC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_block(cfg_block), .cfg_page_en(cfg_page_en),
      .cfg_page_sel(cfg_page_sel), .cfg_ovr_en(cfg_ovr_en), .cfg_dma_only(cfg_dma_only),
      .cfg_dma_kill(cfg_dma_kill), .host_req(host_req), .host_dma(host_dma),
      .host_rdy(host_rdy), .host_grant(host_grant), .sp_sel_n(sp_sel_n), .sp_page(sp_page),
      .sp_rd_n(sp_rd_n), .sp_wr_n(sp_wr_n), .ovr_ack_n(ovr_ack_n), .sp_ack(sp_ack),
      .ovr_req(ovr_req), .sp_rd_oe(sp_rd_oe), .sp_we(sp_we));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // one clock edge, then settle at the falling edge
   task automatic step(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic go_idle();
      host_req = 0; host_dma = 0; sp_sel_n = '1; sp_rd_n = '1; sp_wr_n = '1;
      ovr_ack_n = 1; cfg_page_en = 0; cfg_ovr_en = 0; cfg_dma_only = 0; cfg_dma_kill = 0;
      cfg_block = 2'd1;
      step(MC + 3);
   endtask

   task automatic t_reset();
      chk("R11 ack", 32'(sp_ack), 0);
      chk("R11 ovr_req", 32'(ovr_req), 0);
      chk("R11 grant", 32'(host_grant), 0);
      chk("R11 rdy", 32'(host_rdy), 1);
   endtask

   task automatic t_block();
      cfg_block = 2'd1; sp_sel_n = 3'b110; step();
      chk("R1 other block ignored", 32'(sp_ack), 0);
      sp_sel_n = 3'b101; step();
      chk("R1 block 1 ack", 32'(sp_ack), 32'b010);
      go_idle();
      cfg_block = 2'd3; sp_sel_n = 3'b011; step();
      chk("R1 code 3 no match", 32'(sp_ack), 0);
      sp_sel_n = 3'b110; step();
      chk("R1 code 3 no match b0", 32'(sp_ack), 0);
      go_idle();
   endtask

   task automatic t_page();
      cfg_page_en = 1; cfg_page_sel = 1; sp_page = 0; sp_sel_n = 3'b101; step();
      chk("R2 wrong page", 32'(sp_ack), 0);
      sp_page = 1; step();
      chk("R2 right page", 32'(sp_ack), 32'b010);
      go_idle();
      cfg_page_en = 0; cfg_page_sel = 1; sp_page = 0; sp_sel_n = 3'b101; step();
      chk("R2 filter off", 32'(sp_ack), 32'b010);
      go_idle();
   endtask

   task automatic t_ack_gate();
      ovr_ack_n = 0; sp_sel_n = 3'b101; step(2);
      chk("R3 no ack under override", 32'(sp_ack), 0);
      ovr_ack_n = 1; step();
      chk("R3 ack once released", 32'(sp_ack), 32'b010);
      go_idle();
   endtask

   task automatic t_min_hold();
      int hi;
      hi = 0;
      sp_sel_n = 3'b101; step();
      sp_sel_n = '1;
      if (sp_ack[1]) hi++;
      for (int k = 0; k < MC + 3; k++) begin
         step();
         if (sp_ack[1]) hi++;
      end
      chk("R9 hold length", 32'(hi), MC);
      go_idle();
   endtask

   task automatic t_modes();
      logic [2:0] cases [5];
      logic       exp [5];
      cases[0] = 3'b000; exp[0] = 1;
      cases[1] = 3'b010; exp[1] = 0;
      cases[2] = 3'b100; exp[2] = 1;
      cases[3] = 3'b110; exp[3] = 0;
      cases[4] = 3'b111; exp[4] = 1;
      for (int m = 0; m < 5; m++) begin
         cfg_ovr_en = cases[m][2]; cfg_dma_only = cases[m][1]; host_dma = cases[m][0];
         host_req = 1; step();
         chk($sformatf("R4 mode %b", cases[m]), 32'(ovr_req), 32'(exp[m]));
         host_req = 0; step(2);
      end
      go_idle();
   endtask

   task automatic t_wait();
      cfg_ovr_en = 0; cfg_dma_only = 0; host_req = 1; step(2);
      chk("R5 host stalled", 32'(host_rdy), 0);
      ovr_ack_n = 0; step();
      chk("R5 host granted", 32'(host_grant), 1);
      chk("R5 host ready", 32'(host_rdy), 1);
      go_idle();
   endtask

   task automatic t_kill();
      cfg_ovr_en = 1; cfg_dma_only = 1; cfg_dma_kill = 1;
      host_req = 1; host_dma = 1; sp_sel_n = 3'b101; step();
      chk("R6 dma takes array", 32'(host_grant), 1);
      chk("R6 no ack", 32'(sp_ack), 0);
      go_idle();
      cfg_ovr_en = 0; cfg_dma_only = 1; cfg_dma_kill = 1;
      host_req = 1; host_dma = 1; sp_sel_n = 3'b101; step();
      chk("R6 kill inert ack", 32'(sp_ack), 32'b010);
      chk("R6 kill inert rdy", 32'(host_rdy), 0);
      go_idle();
   endtask

   task automatic t_write();
      sp_sel_n = 3'b101; sp_wr_n = 3'b101; #1;
      chk("R7 early strobe blocked", 32'(sp_we), 0);
      step();
      chk("R7 strobe after ack", 32'(sp_we), 1);
      sp_wr_n = '1; #1;
      chk("R7 strobe released", 32'(sp_we), 0);
      go_idle();
   endtask

   task automatic t_read();
      sp_rd_n = 3'b101; #1;
      chk("R8 oe off without ack", 32'(sp_rd_oe), 0);
      sp_sel_n = 3'b101; step();
      chk("R8 oe on", 32'(sp_rd_oe), 1);
      sp_rd_n = 3'b110; #1;
      chk("R8 other block enable", 32'(sp_rd_oe), 0);
      go_idle();
   endtask

   task automatic t_contest();
      cfg_ovr_en = 0; cfg_dma_only = 1; host_req = 1; sp_sel_n = 3'b101; step();
      chk("R10 second port wins", 32'(sp_ack), 32'b010);
      chk("R10 host waits", 32'(host_rdy), 0);
      sp_sel_n = '1; step(3);
      chk("R10 not yet host", 32'(host_grant), 0);
      step();
      chk("R10 host after sp", 32'(host_grant), 1);
      step(2);
      chk("R10 host held", 32'(host_grant), 1);
      go_idle();
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      t_reset();
      rst_n = 1;
      step();
      t_reset();
      t_block();
      t_page();
      t_ack_gate();
      t_min_hold();
      t_modes();
      t_wait();
      t_kill();
      t_write();
      t_read();
      t_contest();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule